// File: doc/BRIEF.md
# March-Pattern Memory Self-Test Engine

This controller exercises an attached single-port synchronous memory to find defective cells. After a start pulse it walks the whole address space several times. Each walk, called an element, either writes a data word to every address or reads each address and compares the word against what should be there, in some elements followed by a fresh write. Four elements form a march over all-zero and all-one words, in both address directions. Four more write a checkerboard and then its inverse, and read each one back.

Each compared word that differs from its expected value becomes a fault record. The record carries the row, the column and the mask of the bits that disagree, and leaves the engine on a valid/ready stream so that a later repair stage can gather a fault list. When the last element finishes, the engine raises done together with a pass flag. The memory sits outside the block, and the memory address is the row and column joined together.

Top module: `bist_march_engine`

## Requirements
- R1: After reset, and after a reset in the middle of a run, busy, done, fault_valid and mem_en are all low. A start pulse seen while idle or done begins a run, and the engine touches the memory only while busy is high.
- R2: A run performs eight elements in this fixed order: write 0 upward; read 0 then write 1 upward; read 1 then write 0 downward; read 0 downward; write checkerboard upward; read checkerboard upward; write inverse checkerboard upward; read inverse checkerboard upward. Upward starts at address 0 and downward starts at the all-ones address.
- R3: The checkerboard word at an address is all ones when row bit 0 XOR column bit 0 is 1, and all zeros otherwise. The inverse element uses the complement of that word.
- R4: Read data is taken one cycle after the read is issued on mem_en with mem_we low. Each address is read exactly once in each reading element, so an address yields at most one fault record per element.
- R5: When read data differs from the expected word, a record is sent with fault_row equal to the upper ROW_W bits of the address, fault_col equal to the lower COL_W bits, and fault_mask equal to read data XOR expected data. This mask is never zero.
- R6: A record holds fault_valid high, with its fields unchanged, until fault_ready is seen high. While fault_valid is high the engine issues no memory access.
- R7: At the end of a run done goes high and stays high until the next start. pass is high then if, and only if, the run produced no fault record.
- R8: A run issues exactly 5·2^(ROW_W+COL_W) writes and the same number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle or done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | With done: no fault was found |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ROW_W+COL_W | Memory address, {row, column} |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the read |
| fault_valid | output | 1 | A fault record is offered |
| fault_ready | input | 1 | The receiver takes the record |
| fault_row | output | ROW_W | Row of the failing address |
| fault_col | output | COL_W | Column of the failing address |
| fault_mask | output | DATA_W | Bits that differed from the expected word |

## Verification
A wrong element counter or a wrong direction flag changes the order of the fault records. For example, two faulty cells would be reported low-then-high in a downward read, or an extra or missing element would change the read and write totals. Any such error is visible within the run. A slip in the checkerboard parity or in the expected word shows up as a record whose mask comes from the wrong word, or as a record missing from a cell that should fail only one of the two polarities. A broken handshake shows up as a memory access while a record is waiting, or as a lost or duplicated record under backpressure.

// File: rtl/bist_march_pkg.sv
package bist_march_pkg;

   typedef enum logic [2:0] {
      EL_W0_UP   = 3'd0,
      EL_R0W1_UP = 3'd1,
      EL_R1W0_DN = 3'd2,
      EL_R0_DN   = 3'd3,
      EL_WCB_UP  = 3'd4,
      EL_RCB_UP  = 3'd5,
      EL_WCBI_UP = 3'd6,
      EL_RCBI_UP = 3'd7
   } elem_e;

   localparam elem_e EL_LAST = EL_RCBI_UP;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OP, ST_CHECK, ST_REPORT, ST_WRITE, ST_DONE
   } state_e;

   function automatic logic elem_reads(elem_e e);
      return (e == EL_R0W1_UP) || (e == EL_R1W0_DN) || (e == EL_R0_DN) ||
             (e == EL_RCB_UP)  || (e == EL_RCBI_UP);
   endfunction

   function automatic logic elem_read_then_write(elem_e e);
      return (e == EL_R0W1_UP) || (e == EL_R1W0_DN);
   endfunction

   function automatic logic elem_down(elem_e e);
      return (e == EL_R1W0_DN) || (e == EL_R0_DN);
   endfunction

   function automatic logic wr_bit(elem_e e, logic cb);
      case (e)
         EL_R0W1_UP: return 1'b1;
         EL_WCB_UP:  return cb;
         EL_WCBI_UP: return ~cb;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic logic rd_bit(elem_e e, logic cb);
      case (e)
         EL_R1W0_DN: return 1'b1;
         EL_RCB_UP:  return cb;
         EL_RCBI_UP: return ~cb;
         default:    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bist_addr_gen.sv
module bist_addr_gen #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_down,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          at_last
);
   localparam logic [AW-1:0] TOP = '1;

   logic down_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         down_q <= 1'b0;
      end else if (load) begin
         addr   <= load_down ? TOP : '0;
         down_q <= load_down;
      end else if (step) begin
         addr <= down_q ? addr - 1'b1 : addr + 1'b1;
      end
   end

   assign at_last = down_q ? (addr == '0) : (addr == TOP);

   assert_addr_moves_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr != $past(addr)));

endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
   import bist_march_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  elem_e             elem,
   input  logic              row_lsb,
   input  logic              col_lsb,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] exp_data
);
   logic cb;

   always_comb begin
      cb       = row_lsb ^ col_lsb;
      wr_data  = {DATA_W{wr_bit(elem, cb)}};
      exp_data = {DATA_W{rd_bit(elem, cb)}};
   end

endmodule

// File: rtl/bist_fault_port.sv
module bist_fault_port #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic [DATA_W-1:0] in_mask,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ROW_W-1:0]  out_row,
   output logic [COL_W-1:0]  out_col,
   output logic [DATA_W-1:0] out_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_row   <= '0;
         out_col   <= '0;
         out_mask  <= '0;
      end else if (capture) begin
         out_valid <= 1'b1;
         out_row   <= in_row;
         out_col   <= in_col;
         out_mask  <= in_mask;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_record_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_row) && $stable(out_col) && $stable(out_mask)));

   assert_mask_nonzero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mask != '0));

endmodule

// File: rtl/bist_march_engine.sv
module bist_march_engine
   import bist_march_pkg::*;
#(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic                     busy,
   output logic                     done,
   output logic                     pass,
   output logic                     mem_en,
   output logic                     mem_we,
   output logic [ROW_W+COL_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic                     fault_valid,
   input  logic                     fault_ready,
   output logic [ROW_W-1:0]         fault_row,
   output logic [COL_W-1:0]         fault_col,
   output logic [DATA_W-1:0]        fault_mask
);
   localparam int AW = ROW_W + COL_W;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_geometry
      $error("bist_march_engine: ROW_W and COL_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("bist_march_engine: DATA_W must be at least 1");
   end
   if (AW > 24) begin : g_bad_span
      $error("bist_march_engine: address span too large for a self-test run");
   end

   state_e            state_q, state_d;
   elem_e             elem_q, elem_d;
   logic              fail_q, fail_d;
   logic [AW-1:0]     addr;
   logic              at_last;
   logic              adv, ld, ld_down, capture;
   logic [DATA_W-1:0] wr_data, exp_data, diff;
   elem_e             elem_nx;

   bist_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_down(ld_down),
      .step(adv && !at_last), .addr(addr), .at_last(at_last));

   bist_pattern_gen #(.DATA_W(DATA_W)) u_pat (
      .elem(elem_q), .row_lsb(addr[COL_W]), .col_lsb(addr[0]),
      .wr_data(wr_data), .exp_data(exp_data));

   bist_fault_port #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_fault (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .in_row(addr[AW-1:COL_W]), .in_col(addr[COL_W-1:0]), .in_mask(diff),
      .out_valid(fault_valid), .out_ready(fault_ready),
      .out_row(fault_row), .out_col(fault_col), .out_mask(fault_mask));

   assign diff    = mem_rdata ^ exp_data;
   assign elem_nx = elem_e'(elem_q + 3'd1);

   always_comb begin
      state_d = state_q;
      elem_d  = elem_q;
      fail_d  = fail_q;
      adv     = 1'b0;
      ld      = 1'b0;
      ld_down = 1'b0;
      capture = 1'b0;
      case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               state_d = ST_OP;
               elem_d  = EL_W0_UP;
               fail_d  = 1'b0;
               ld      = 1'b1;
               ld_down = elem_down(EL_W0_UP);
            end
         end
         ST_OP: begin
            if (elem_reads(elem_q)) state_d = ST_CHECK;
            else                    adv     = 1'b1;
         end
         ST_CHECK: begin
            if (diff != '0) begin
               capture = 1'b1;
               fail_d  = 1'b1;
               state_d = ST_REPORT;
            end else if (elem_read_then_write(elem_q)) begin
               state_d = ST_WRITE;
            end else begin
               adv = 1'b1;
            end
         end
         ST_REPORT: begin
            if (fault_ready) begin
               if (elem_read_then_write(elem_q)) state_d = ST_WRITE;
               else                              adv     = 1'b1;
            end
         end
         ST_WRITE: adv = 1'b1;
         default:  state_d = ST_IDLE;
      endcase

      if (adv) begin
         state_d = ST_OP;
         if (at_last) begin
            if (elem_q == EL_LAST) begin
               state_d = ST_DONE;
            end else begin
               elem_d  = elem_nx;
               ld      = 1'b1;
               ld_down = elem_down(elem_nx);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         elem_q  <= EL_W0_UP;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         elem_q  <= elem_d;
         fail_q  <= fail_d;
      end
   end

   assign mem_en    = (state_q == ST_OP) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE) || ((state_q == ST_OP) && !elem_reads(elem_q));
   assign mem_addr  = addr;
   assign mem_wdata = wr_data;
   assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done      = (state_q == ST_DONE);
   assign pass      = done && !fail_q;

   assert_access_busy_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> busy);

   assert_quiet_stall_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !mem_en);

   assert_done_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !fault_valid && !mem_en));

   assert_done_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_read_checked_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> !mem_en);

endmodule

// File: tb/bist_march_engine_test.sv
module bist_march_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 3;
   localparam int CW = 3;
   localparam int DW = 8;
   localparam int AW = RW + CW;
   localparam int N  = 1 << AW;

   typedef struct packed {
      logic [5:0] fa;
      logic [7:0] sa0a;
      logic [7:0] sa1a;
      logic [5:0] fb;
      logic [7:0] sa0b;
      logic [7:0] sa1b;
      logic [2:0] stall;
   } scen_t;

   localparam int NSC = 6;
   localparam scen_t SCEN [NSC] = '{
      '{6'd0,  8'h00, 8'h00, 6'd0,  8'h00, 8'h00, 3'd0},
      '{6'd0,  8'h00, 8'h01, 6'd0,  8'h00, 8'h00, 3'd0},
      '{6'd63, 8'hFF, 8'h00, 6'd63, 8'h00, 8'h00, 3'd2},
      '{6'd5,  8'h00, 8'h80, 6'd40, 8'h00, 8'h80, 3'd3},
      '{6'd9,  8'h0F, 8'hF0, 6'd9,  8'h00, 8'h00, 3'd1},
      '{6'd18, 8'h02, 8'h00, 6'd10, 8'h00, 8'h01, 3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, pass, mem_en, mem_we, fault_valid;
   logic fault_ready = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, fault_mask;
   logic [RW-1:0] fault_row;
   logic [CW-1:0] fault_col;

   logic [DW-1:0] mem [N];
   logic [DW-1:0] sa0 [N];
   logic [DW-1:0] sa1 [N];

   int n_chk = 0, n_bad = 0, cycles = 0;
   int n_wr = 0, n_rd = 0, cur_stall = 0, wait_cnt = 0;
   bit stall_bad = 0;
   int got_n = 0, exp_n = 0;
   logic [AW-1:0] got_a [32];
   logic [DW-1:0] got_m [32];
   logic [AW-1:0] exp_a [32];
   logic [DW-1:0] exp_m [32];

   bist_march_engine #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .fault_valid(fault_valid), .fault_ready(fault_ready),
      .fault_row(fault_row), .fault_col(fault_col), .fault_mask(fault_mask));

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_en && !mem_we) mem_rdata <= (mem[mem_addr] & ~sa0[mem_addr]) | sa1[mem_addr];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   // Receiver, access monitor and stall monitor, all away from the rising edge.
   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (mem_en && mem_we) n_wr++;
         if (mem_en && !mem_we) n_rd++;
         if (fault_valid && mem_en) stall_bad = 1;
         if (fault_valid) begin
            if (wait_cnt >= cur_stall) begin
               fault_ready = 1'b1;
               if (got_n < 32) begin
                  got_a[got_n] = {fault_row, fault_col};
                  got_m[got_n] = fault_mask;
               end
               got_n++;
               wait_cnt = 0;
            end else begin
               fault_ready = 1'b0;
               wait_cnt++;
            end
         end else begin
            fault_ready = 1'b0;
            wait_cnt = 0;
         end
      end
   end

   // Expected record list from R2/R3/R5: walk reading elements in order.
   task automatic build_expected();
      exp_n = 0;
      for (int e = 0; e < 8; e++) begin
         bit rd, dn;
         rd = (e == 1) || (e == 2) || (e == 3) || (e == 5) || (e == 7);
         dn = (e == 2) || (e == 3);
         if (rd) begin
            for (int i = 0; i < N; i++) begin
               int a;
               logic cb;
               logic [DW-1:0] ev, rv;
               a  = dn ? (N - 1 - i) : i;
               cb = a[CW] ^ a[0];
               case (e)
                  2: ev = '1;
                  5: ev = {DW{cb}};
                  7: ev = {DW{~cb}};
                  default: ev = '0;
               endcase
               rv = (ev & ~sa0[a]) | sa1[a];
               if ((ev ^ rv) != '0) begin
                  exp_a[exp_n] = a[AW-1:0];
                  exp_m[exp_n] = ev ^ rv;
                  exp_n++;
               end
            end
         end
      end
   endtask

   task automatic run_once(output bit finished);
      int lim;
      n_wr = 0; n_rd = 0; got_n = 0; stall_bad = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      lim = 0;
      while (!done && lim < 20000) begin
         @(negedge clk);
         lim++;
      end
      finished = done;
   endtask

   initial begin
      bit fin;
      for (int i = 0; i < N; i++) begin
         sa0[i] = '0; sa1[i] = '0; mem[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !fault_valid && !mem_en, "R1 reset outputs quiet",
            {busy, done, fault_valid, mem_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done, "R1 idle without start", {busy, done}, 0);

      // Scenario table walk
      for (int s = 0; s < NSC; s++) begin
         for (int i = 0; i < N; i++) begin sa0[i] = '0; sa1[i] = '0; end
         sa0[SCEN[s].fa] = SCEN[s].sa0a;  sa1[SCEN[s].fa] = SCEN[s].sa1a;
         sa0[SCEN[s].fb] = sa0[SCEN[s].fb] | SCEN[s].sa0b;
         sa1[SCEN[s].fb] = sa1[SCEN[s].fb] | SCEN[s].sa1b;
         cur_stall = int'(SCEN[s].stall);
         build_expected();
         run_once(fin);
         check(fin, "R7 done reached", int'(done), 1);
         check(pass == (exp_n == 0), "R7 pass flag", int'(pass), int'(exp_n == 0));
         check(n_wr == 5 * N, "R8 write count", n_wr, 5 * N);
         check(n_rd == 5 * N, "R8 read count", n_rd, 5 * N);
         check(!stall_bad, "R6 no access while record waits", int'(stall_bad), 0);
         check(got_n == exp_n, "R4 record count", got_n, exp_n);
         for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(got_a[k] == exp_a[k], "R5 R2 record address (row,col)",
                  int'(got_a[k]), int'(exp_a[k]));
            check(got_m[k] == exp_m[k], "R5 R3 record mask",
                  int'(got_m[k]), int'(exp_m[k]));
         end
         repeat (4) @(negedge clk);
         check(done && pass == (exp_n == 0), "R7 done and pass held", {done, pass}, 2 + (exp_n == 0));
      end

      // R1: reset in the middle of a run
      for (int i = 0; i < N; i++) begin sa0[i] = '0; sa1[i] = '0; end
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (100) @(negedge clk);
      check(busy, "R1 busy during run", int'(busy), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!busy && !done && !fault_valid && !mem_en, "R1 mid-run reset quiet",
            {busy, done, fault_valid, mem_en}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!busy && !mem_en, "R1 stays idle after reset", {busy, mem_en}, 0);

      // R1: restart after reset runs clean
      run_once(fin);
      check(fin && pass, "R1 R7 clean run after reset", {fin, pass}, 3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule